// File: doc/BRIEF.md
# Staggered Offset-Switching Bus Lane

This block carries a parallel word across a long run of wire without letting neighbouring lines switch at the same moment. Each system period is cut into B equal phase slots. Within a section of B bits, bit j is put onto its physical line j slots after bit 0. At the far end the word is lined up again, so every bit reaches the output register in the same system cycle. A wide bus is a stack of identical B-bit sections that share one set of phase enables.

The model runs on a single fast clock, one edge per phase slot. A one-hot phase ring enables the hold stages in place of level-sensitive latches. A send interface register captures the input word once per system period. Every bit then passes through exactly B enabled hold stages: j+1 of them before the wire and B-1-j after it. The wire is modelled as an optional pipeline of D phase slots. A receive interface register presents the realigned word, and a valid flag rises once the first captured word has arrived.

Top module: `sb_stagger_lane`

## Requirements
- R1: With L = 2 + floor(D/B) system periods, out_word after a system edge equals the word captured at the system edge L periods earlier. This holds for every bit of every section.
- R2: slot resets to 0 and advances by one on every clock edge, wrapping from B-1 to 0. A system edge is a clock edge at which slot is B-1. in_word is sampled only at system edges. Values it holds at any other edge have no effect on out_word.
- R3: Take bit i of line_bus and let j = i mod B. That bit changes only at a clock edge at which slot equals (j+D) mod B. out_word changes only at system edges.
- R4: No two adjacent bits of line_bus change at the same clock edge. This includes the pair of bits on either side of a section boundary.
- R5: While rst is high, slot is 0 and out_word, out_valid, line_bus and every stage are 0. This applies both at start-up and when rst is raised mid-stream.
- R6: out_valid is low for the first L system edges after reset. It goes high at system edge L+1 and stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-slot clock, B edges per system period |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | B*SECTIONS | Word to send, sampled at system edges |
| out_word | output | B*SECTIONS | Realigned received word |
| out_valid | output | 1 | High once received words are real |
| line_bus | output | B*SECTIONS | State of the physical bit lines |
| slot | output | $clog2(B) | Current phase slot index |

## Verification
The bench builds two instances. The first has B=4, two sections and D=1, so the wire delay does not divide the period and the launch slots are rotated by one. The second has B=2, four sections and D=3, so the wire delay exceeds a period and the latency grows to three system cycles. Both instances are swept with all 256 byte values, each followed by its complement, so every line toggles at its highest rate. Junk is driven on the input between system edges. A reset is also applied in mid-stream. Slot ownership and adjacency are checked at every phase edge.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // Phase slot that enables hold stage k of bit j; stages beyond the send
  // side are pushed later by the wire delay so they sample settled data.
  function automatic int stage_slot(input int k, input int j, input int d, input int b);
    if (k <= j) return k;
    return (k + d) % b;
  endfunction

  // Slot whose edge makes bit j's physical line change.
  function automatic int launch_slot(input int j, input int d, input int b);
    return (j + d) % b;
  endfunction

  // System periods from input capture to output presentation.
  function automatic int sys_latency(input int d, input int b);
    return 2 + d / b;
  endfunction

endpackage

// File: rtl/sb_phase_gen.sv
module sb_phase_gen #(
  parameter int B = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [$clog2(B)-1:0] slot_o,
  output logic [B-1:0]         en_o,
  output logic                 sys_edge_o
);
  localparam int SW = $clog2(B);
  localparam logic [SW-1:0] LAST = SW'(B - 1);

  logic [SW-1:0] slot_q;
  logic [B-1:0]  ring_q;

  // Counter and one-hot ring run side by side; the ring feeds the stage
  // enables, the counter is visible at the port.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      ring_q <= B'(1);
    end else begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      ring_q <= {ring_q[B-2:0], ring_q[B-1]};
    end
  end

  // For B=2 the two ring bits are simply the system clock level and its complement.
  assign slot_o     = slot_q;
  assign en_o       = ring_q;
  assign sys_edge_o = ring_q[B-1];

  a_r2_ring_matches_count: assert property (@(posedge clk) disable iff (rst)
    ring_q[slot_q] && $onehot0(ring_q));
  a_r2_slot_wraps: assert property (@(posedge clk) disable iff (rst)
    (slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/sb_bit_chain.sv
module sb_bit_chain #(
  parameter int B = 4,
  parameter int J = 0,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [B-1:0] en_i,
  input  logic         d_i,
  output logic         line_o,
  output logic         q_o
);
  localparam int LAUNCH = sb_pkg::launch_slot(J, D, B);
  localparam int ALIGN  = sb_pkg::launch_slot(B - 1, D, B);

  logic [B-1:0] st_q;
  logic [B-1:0] en_sel;
  logic [B-1:0] nxt;
  logic         wire_out;

  for (genvar k = 0; k < B; k++) begin : g_stage
    localparam int SS = sb_pkg::stage_slot(k, J, D, B);
    assign en_sel[k] = en_i[SS];
    if (k == 0) begin : g_first
      assign nxt[k] = d_i;
    end else if (k == J + 1) begin : g_rx_head
      assign nxt[k] = wire_out;
    end else begin : g_link
      assign nxt[k] = st_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else begin
      for (int k = 0; k < B; k++)
        if (en_sel[k]) st_q[k] <= nxt[k];
    end
  end

  // Wire model: D phase slots of pure delay after the last send-side stage.
  if (D == 0) begin : g_nowire
    assign wire_out = st_q[J];
  end else begin : g_wire
    logic [D-1:0] dl_q;
    always_ff @(posedge clk) begin
      if (rst) dl_q <= '0;
      else begin
        dl_q[0] <= st_q[J];
        for (int i = 1; i < D; i++) dl_q[i] <= dl_q[i-1];
      end
    end
    assign wire_out = dl_q[D-1];
  end

  assign line_o = wire_out;

  if (J == B - 1) begin : g_tail_wire
    assign q_o = wire_out;
  end else begin : g_tail_stage
    assign q_o = st_q[B-1];
  end

  a_r3_line_in_own_slot: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> $past(en_i[LAUNCH]));
  a_r1_realigned_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(q_o) |-> $past(en_i[ALIGN]));
endmodule

// File: rtl/sb_section.sv
module sb_section #(
  parameter int B = 4,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [B-1:0] en_i,
  input  logic [B-1:0] d_i,
  output logic [B-1:0] line_o,
  output logic [B-1:0] q_o
);
  for (genvar j = 0; j < B; j++) begin : g_bit
    sb_bit_chain #(.B(B), .J(j), .D(D)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .en_i   (en_i),
      .d_i    (d_i[j]),
      .line_o (line_o[j]),
      .q_o    (q_o[j])
    );
  end

  for (genvar j = 0; j < B - 1; j++) begin : g_adj
    a_r4_neighbours_apart: assert property (@(posedge clk) disable iff (rst)
      !(!$stable(line_o[j]) && !$stable(line_o[j+1])));
  end
endmodule

// File: rtl/sb_stagger_lane.sv
module sb_stagger_lane #(
  parameter int BITS_PER_SEC = 4,
  parameter int SECTIONS     = 2,
  parameter int LINE_DELAY   = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [BITS_PER_SEC*SECTIONS-1:0] in_word,
  output logic [BITS_PER_SEC*SECTIONS-1:0] out_word,
  output logic                            out_valid,
  output logic [BITS_PER_SEC*SECTIONS-1:0] line_bus,
  output logic [$clog2(BITS_PER_SEC)-1:0] slot
);
  localparam int B   = BITS_PER_SEC;
  localparam int N   = B * SECTIONS;
  localparam int L   = sb_pkg::sys_latency(LINE_DELAY, B);
  localparam int CW  = $clog2(L + 2);
  localparam logic [CW-1:0] LCNT = CW'(L);

  logic [B-1:0] phase_en;
  logic         sys_edge;
  logic [N-1:0] tx_q;
  logic [N-1:0] aligned;
  logic [CW-1:0] cnt_q;

  sb_phase_gen #(.B(B)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .slot_o     (slot),
    .en_o       (phase_en),
    .sys_edge_o (sys_edge)
  );

  // Send-side interface register.
  always_ff @(posedge clk) begin
    if (rst) tx_q <= '0;
    else if (sys_edge) tx_q <= in_word;
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    sb_section #(.B(B), .D(LINE_DELAY)) u_sec (
      .clk    (clk),
      .rst    (rst),
      .en_i   (phase_en),
      .d_i    (tx_q[s*B +: B]),
      .line_o (line_bus[s*B +: B]),
      .q_o    (aligned[s*B +: B])
    );
  end

  // Receive-side interface register and fill tracking.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= 1'b0;
      cnt_q     <= '0;
    end else if (sys_edge) begin
      out_word  <= aligned;
      out_valid <= out_valid | (cnt_q == LCNT);
      if (cnt_q != LCNT) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar s = 1; s < SECTIONS; s++) begin : g_seam
    a_r4_seam_apart: assert property (@(posedge clk) disable iff (rst)
      !(!$stable(line_bus[s*B-1]) && !$stable(line_bus[s*B])));
  end

  a_r3_out_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(sys_edge) |-> $stable(out_word));
  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
  a_r5_reset_clears: assert property (@(posedge clk)
    rst |=> (out_word == '0 && !out_valid && line_bus == '0 && slot == '0));
endmodule

// File: tb/test_sb_stagger_lane.sv
module test_sb_stagger_lane;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] din_a = '0, din_b = '0;
  logic [7:0] dout_a, dout_b, line_a, line_b;
  logic       vld_a, vld_b;
  logic [1:0] slot_a;
  logic [0:0] slot_b;

  sb_stagger_lane #(.BITS_PER_SEC(4), .SECTIONS(2), .LINE_DELAY(1)) i_sb_stagger_lane (
    .clk(clk), .rst(rst), .in_word(din_a), .out_word(dout_a),
    .out_valid(vld_a), .line_bus(line_a), .slot(slot_a));

  sb_stagger_lane #(.BITS_PER_SEC(2), .SECTIONS(4), .LINE_DELAY(3)) i_sb_stagger_lane_w2 (
    .clk(clk), .rst(rst), .in_word(din_b), .out_word(dout_b),
    .out_valid(vld_b), .line_bus(line_b), .slot(slot_b));

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] get_dout(input int c);  return c == 0 ? dout_a : dout_b; endfunction
  function automatic logic [7:0] get_line(input int c);  return c == 0 ? line_a : line_b; endfunction
  function automatic logic       get_vld(input int c);   return c == 0 ? vld_a : vld_b; endfunction
  function automatic int         get_slot(input int c);  return c == 0 ? int'(slot_a) : int'(slot_b); endfunction

  task automatic set_din(input int c, input logic [7:0] w);
    if (c == 0) din_a = w; else din_b = w;
  endtask

  task automatic run_cfg(input int c, input int b, input int d, input int nwords);
    int lat;
    int s;
    int exp_ph;
    logic [7:0] prev_line;
    logic [7:0] ch;
    logic [7:0] allowed;
    logic [7:0] v;
    logic [7:0] w;
    logic [7:0] exp_w;
    bit exp_v;
    logic [7:0] hist [0:1023];
    lat = 2 + d / b;
    s = 0;
    exp_ph = 0;
    prev_line = '0;
    while (s <= nwords + lat) begin
      @(negedge clk);
      exp_ph = (exp_ph + 1) % b;
      chk(get_slot(c) == exp_ph, "R2 slot count", get_slot(c), exp_ph);
      ch = get_line(c) ^ prev_line;
      prev_line = get_line(c);
      allowed = '0;
      for (int i = 0; i < 8; i++)
        if (((i % b) + d + 1) % b == exp_ph) allowed[i] = 1'b1;
      chk((ch & ~allowed) == 8'h00, "R3 line changed outside its slot", ch, ch & allowed);
      chk((ch & (ch >> 1)) == 8'h00, "R4 adjacent lines changed together", ch, 0);
      if (exp_ph == 0 && s > 0) begin
        exp_v = (s >= lat + 1);
        exp_w = exp_v ? hist[s-lat] : 8'h00;
        chk(get_vld(c) == exp_v, "R6 out_valid", get_vld(c), exp_v);
        chk(get_dout(c) == exp_w, "R1 received word", get_dout(c), exp_w);
      end
      if (exp_ph == b - 1) begin
        s++;
        v = 8'((s - 1) >> 1);
        w = s[0] ? v : ~v;
        hist[s] = w;
        set_din(c, w);
      end else begin
        // R2: junk between system edges must never reach the output
        set_din(c, 8'(s * 37 + exp_ph * 11 + 5));
      end
    end
  endtask

  task automatic reset_check(input string tag);
    chk(dout_a == 0 && dout_b == 0, {"R5 out_word ", tag}, {dout_a, dout_b}, 0);
    chk(!vld_a && !vld_b, {"R5 out_valid ", tag}, {vld_a, vld_b}, 0);
    chk(line_a == 0 && line_b == 0, {"R5 line_bus ", tag}, {line_a, line_b}, 0);
    chk(slot_a == 0 && slot_b == 0, {"R5 slot ", tag}, {slot_a, slot_b}, 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    reset_check("start");
    rst = 1'b0;
    fork
      run_cfg(0, 4, 1, 512);
      run_cfg(1, 2, 3, 512);
    join
    @(negedge clk);
    din_a = 8'hA5;
    din_b = 8'h5A;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    reset_check("mid-stream");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule